// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Arbiter

This block sits beside a small 8-bit processor core and decides which of five interrupt sources the core should service next. One source cannot be masked and always wins. Three restart sources each lead to a fixed vector address. The fifth is a general-purpose request whose opcode the core must fetch from the bus. For that source the block drives an active-low acknowledge strobe.

The core sees one pending flag and one vector address. A separate flag says that the winning source is the externally vectored one. To accept the interrupt, the core pulses `irq_take` while the flag is up. The block then does the housekeeping that belongs to the accepted source:
- For any maskable source, it clears the global enable.
- For the top restart source, it drops that source's latched request.
- For the external source, it drives the acknowledge strobe.

The core controls the block through three write paths:
- It sets or clears the global enable.
- It writes the three restart mask bits, and in the same write it can discard a latched top-restart request.
- It reads one status byte.

Top module: `vec_irq_arbiter`

## Requirements
- R1: After reset the three mask bits are all 1 (masked), the global enable is 0, nothing is pending, `gen_ack_n` is 1 and `stat_out` reads 8'h07.
- R2: A recognised non-maskable request has the highest priority, whatever the mask bits or the global enable. It gives `irq_pending`=1, `irq_vector`=16'h0024 and `irq_ext`=0.
- R3: The non-maskable source is recognised only after a rising edge on `nmi_in`, and only while `nmi_in` stays high. Dropping the line withdraws it. After it is taken, a line that stays high does not request again.
- R4: Among the restart sources, `rst_hi_in` beats `rst_mid_in`, which beats `rst_lo_in`. Their vectors are 16'h003C, 16'h0034 and 16'h002C. Every restart source beats the general request.
- R5: A maskable source is presented only when the global enable is 1 and its mask bit is 0. In `mask_wdata`, bit 2 masks the top restart source, bit 1 the middle one and bit 0 the bottom one.
- R6: A rising edge on `rst_hi_in` is latched, even while that source is masked or the enable is 0. It stays latched after the input returns low.
- R7: `rst_mid_in`, `rst_lo_in` and `gen_req_in` are level-sensitive. Removing the level withdraws the request in the same cycle.
- R8: When the general request wins, `irq_ext`=1 and `irq_vector`=0. Taking it drives `gen_ack_n` low for ACK_LEN cycles (2 by default), starting in the cycle after the take.
- R9: Taking any maskable source clears the global enable. Taking the non-maskable source leaves the enable unchanged.
- R10: The latched top-restart request is cleared in two cases: when it is taken, or by a mask write with `mask_clr_hi`=1.
- R11: `stat_out` is formed as follows:
  - [2:0] holds the mask bits.
  - [3] holds the global enable.
  - [4] holds the `rst_lo_in` level.
  - [5] holds the `rst_mid_in` level.
  - [6] holds the latched top-restart flag.
  - [7] holds the recognised non-maskable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request line |
| rst_hi_in | input | 1 | Top restart request, edge-latched |
| rst_mid_in | input | 1 | Middle restart request, level |
| rst_lo_in | input | 1 | Bottom restart request, level |
| gen_req_in | input | 1 | General-purpose request, level |
| ie_set | input | 1 | Set the global enable |
| ie_clr | input | 1 | Clear the global enable |
| mask_we | input | 1 | Write the mask bits |
| mask_wdata | input | 3 | New mask bits, 1 = masked |
| mask_clr_hi | input | 1 | With mask_we, discard the latched top-restart request |
| irq_take | input | 1 | Core accepts the presented interrupt |
| irq_pending | output | 1 | An interrupt is presented |
| irq_vector | output | VEC_W | Vector of the presented source, 0 for the external one |
| irq_ext | output | 1 | Presented source is the externally vectored one |
| gen_ack_n | output | 1 | Active-low acknowledge for the general request |
| stat_out | output | 8 | Status read word |

## Verification
A corrupted mask bit, enable bit or latched flag shows up at the ports at once. `stat_out` carries all of that state directly. The combinational selector also turns it into a wrong `irq_pending` or `irq_vector` in the same cycle, so a sweep over every mask, enable and request combination catches it where it arises. Errors in the take bookkeeping appear one cycle after `irq_take`: the enable or latched flag fails to clear, or `gen_ack_n` stays low for the wrong number of cycles.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   localparam int N_RST = 3;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_NMI  = 3'd1,
      SRC_HI   = 3'd2,
      SRC_MID  = 3'd3,
      SRC_LO   = 3'd4,
      SRC_EXT  = 3'd5
   } irq_src_e;

   // restart channel index: higher index = higher priority
   function automatic irq_src_e idx_to_src(input int idx);
      case (idx)
         2:       return SRC_HI;
         1:       return SRC_MID;
         default: return SRC_LO;
      endcase
   endfunction

endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
   parameter bit NEED_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   input  logic clr,
   output logic pend_o
);

   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise = req_in & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= req_in;
   end

   generate
      if (NEED_LEVEL) begin : g_edge_level
         always_ff @(posedge clk) begin
            if (!rst_n)      pend_q <= 1'b0;
            else if (rise)   pend_q <= 1'b1;
            else if (clr || !req_in) pend_q <= 1'b0;
         end
         assign pend_o = pend_q & req_in;

         // R3
         drop_withdraws_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_in) |=> (!pend_q || $past(rise) == 1'b0 && req_in));
      end else begin : g_edge_only
         always_ff @(posedge clk) begin
            if (!rst_n)    pend_q <= 1'b0;
            else if (rise) pend_q <= 1'b1;
            else if (clr)  pend_q <= 1'b0;
         end
         assign pend_o = pend_q;

         // R6
         latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && !clr) |=> pend_q);
      end
   endgenerate

   // R6
   rise_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_in && !prev_q) |=> pend_q);

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
   parameter int N_CH = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mask_we,
   input  logic [N_CH-1:0] mask_wdata,
   input  logic            ie_set,
   input  logic            ie_clr,
   input  logic            take_mask,
   output logic [N_CH-1:0] mask_q,
   output logic            ie_q
);

   generate
      if (N_CH < 1) begin : g_bad_ch
         $error("irq_mask_regs: N_CH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '1;
      else if (mask_we) mask_q <= mask_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         ie_q <= 1'b0;
      else if (take_mask) ie_q <= 1'b0;
      else if (ie_clr)    ie_q <= 1'b0;
      else if (ie_set)    ie_q <= 1'b1;
   end

   // R9
   take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_mask |=> !ie_q);

   // R5
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(mask_wdata)));

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import irq_arb_pkg::*;
#(
   parameter int               VEC_W   = 16,
   parameter logic [VEC_W-1:0] VEC_NMI = 'h24,
   parameter logic [VEC_W-1:0] VEC_HI  = 'h3C,
   parameter logic [VEC_W-1:0] VEC_MID = 'h34,
   parameter logic [VEC_W-1:0] VEC_LO  = 'h2C
) (
   input  logic             nmi_req,
   input  logic [N_RST-1:0] rst_req,
   input  logic [N_RST-1:0] rst_mask,
   input  logic             ie,
   input  logic             ext_req,
   output irq_src_e         src,
   output logic [VEC_W-1:0] vec
);

   localparam logic [VEC_W-1:0] VEC_TAB [N_RST] = '{VEC_LO, VEC_MID, VEC_HI};

   generate
      if (VEC_W < 8) begin : g_bad_w
         $error("irq_prio_sel: VEC_W must be at least 8");
      end
   endgenerate

   logic [N_RST-1:0] live;
   assign live = rst_req & ~rst_mask;

   always_comb begin
      logic found;
      found = 1'b0;
      src   = SRC_NONE;
      vec   = '0;
      if (nmi_req) begin
         src = SRC_NMI;
         vec = VEC_NMI;
      end else if (ie) begin
         for (int i = N_RST - 1; i >= 0; i--) begin
            if (!found && live[i]) begin
               found = 1'b1;
               src   = idx_to_src(i);
               vec   = VEC_TAB[i];
            end
         end
         if (!found && ext_req) src = SRC_EXT;
      end
   end

endmodule

// File: rtl/irq_ack_gen.sv
module irq_ack_gen #(
   parameter int ACK_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ack_n
);

   localparam int CW = $clog2(ACK_LEN + 1);

   generate
      if (ACK_LEN < 1) begin : g_bad_len
         $error("irq_ack_gen: ACK_LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= CW'(ACK_LEN);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign ack_n = (cnt_q == '0);

   // R8
   ack_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ack_n);

   // R8
   ack_only_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n) |-> $past(start));

endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int               VEC_W   = 16,
   parameter int               ACK_LEN = 2,
   parameter logic [VEC_W-1:0] VEC_NMI = 'h24,
   parameter logic [VEC_W-1:0] VEC_HI  = 'h3C,
   parameter logic [VEC_W-1:0] VEC_MID = 'h34,
   parameter logic [VEC_W-1:0] VEC_LO  = 'h2C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_in,
   input  logic             rst_hi_in,
   input  logic             rst_mid_in,
   input  logic             rst_lo_in,
   input  logic             gen_req_in,
   input  logic             ie_set,
   input  logic             ie_clr,
   input  logic             mask_we,
   input  logic [2:0]       mask_wdata,
   input  logic             mask_clr_hi,
   input  logic             irq_take,
   output logic             irq_pending,
   output logic [VEC_W-1:0] irq_vector,
   output logic             irq_ext,
   output logic             gen_ack_n,
   output logic [7:0]       stat_out
);

   generate
      if (N_RST != 3) begin : g_bad_n
         $error("vec_irq_arbiter: exactly three restart channels supported");
      end
   endgenerate

   logic             nmi_vis;
   logic             hi_pend;
   logic [N_RST-1:0] mask_q;
   logic             ie_q;
   irq_src_e         src;
   logic             take_eff;
   logic             take_nmi;
   logic             take_hi;
   logic             take_mask;
   logic             take_ext;

   assign take_eff  = irq_take & irq_pending;
   assign take_nmi  = take_eff & (src == SRC_NMI);
   assign take_hi   = take_eff & (src == SRC_HI);
   assign take_ext  = take_eff & (src == SRC_EXT);
   assign take_mask = take_eff & (src != SRC_NMI);

   irq_edge_pend #(.NEED_LEVEL(1'b1)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_in (nmi_in),
      .clr    (take_nmi),
      .pend_o (nmi_vis)
   );

   irq_edge_pend #(.NEED_LEVEL(1'b0)) u_hi (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_in (rst_hi_in),
      .clr    (take_hi | (mask_we & mask_clr_hi)),
      .pend_o (hi_pend)
   );

   irq_mask_regs #(.N_CH(N_RST)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (mask_we),
      .mask_wdata (mask_wdata),
      .ie_set     (ie_set),
      .ie_clr     (ie_clr),
      .take_mask  (take_mask),
      .mask_q     (mask_q),
      .ie_q       (ie_q)
   );

   irq_prio_sel #(
      .VEC_W   (VEC_W),
      .VEC_NMI (VEC_NMI),
      .VEC_HI  (VEC_HI),
      .VEC_MID (VEC_MID),
      .VEC_LO  (VEC_LO)
   ) u_sel (
      .nmi_req  (nmi_vis),
      .rst_req  ({hi_pend, rst_mid_in, rst_lo_in}),
      .rst_mask (mask_q),
      .ie       (ie_q),
      .ext_req  (gen_req_in),
      .src      (src),
      .vec      (irq_vector)
   );

   irq_ack_gen #(.ACK_LEN(ACK_LEN)) u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take_ext),
      .ack_n (gen_ack_n)
   );

   assign irq_pending = (src != SRC_NONE);
   assign irq_ext     = (src == SRC_EXT);
   assign stat_out    = {nmi_vis, hi_pend, rst_mid_in, rst_lo_in, ie_q, mask_q};

   // R2
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_vis |-> (irq_pending && irq_vector == VEC_NMI && !irq_ext));

   // R5
   enable_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !nmi_vis) |-> !irq_pending);

   // R9
   nmi_keeps_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_nmi && !ie_set && !ie_clr) |=> (ie_q == $past(ie_q)));

   // R10
   hi_taken_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hi && $stable(rst_hi_in)) |=> !hi_pend);

endmodule

// File: tb/tb_vec_irq_arbiter.sv
module tb_vec_irq_arbiter;

   localparam int ACK = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_in = 0, rst_hi_in = 0, rst_mid_in = 0, rst_lo_in = 0, gen_req_in = 0;
   logic        ie_set = 0, ie_clr = 0, mask_we = 0, mask_clr_hi = 0, irq_take = 0;
   logic [2:0]  mask_wdata = 3'b000;
   logic        irq_pending, irq_ext, gen_ack_n;
   logic [15:0] irq_vector;
   logic [7:0]  stat_out;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   vec_irq_arbiter #(.VEC_W(16), .ACK_LEN(ACK)) dut (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .rst_hi_in(rst_hi_in),
      .rst_mid_in(rst_mid_in), .rst_lo_in(rst_lo_in), .gen_req_in(gen_req_in),
      .ie_set(ie_set), .ie_clr(ie_clr), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .mask_clr_hi(mask_clr_hi), .irq_take(irq_take), .irq_pending(irq_pending),
      .irq_vector(irq_vector), .irq_ext(irq_ext), .gen_ack_n(gen_ack_n),
      .stat_out(stat_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      ie_set = 0; ie_clr = 0; mask_we = 0; mask_clr_hi = 0; irq_take = 0;
   endtask

   task automatic write_mask(input logic [2:0] m, input logic clr);
      cyc();
      mask_we = 1; mask_wdata = m; mask_clr_hi = clr;
   endtask

   task automatic set_ie(input logic v);
      cyc();
      ie_set = v; ie_clr = ~v;
   endtask

   task automatic pulse_hi();
      cyc(); rst_hi_in = 1;
      cyc(); rst_hi_in = 0;
   endtask

   function automatic logic [17:0] expect_sel(input logic [2:0] m, input logic ie,
                                               input logic hp, input logic mid,
                                               input logic lo, input logic gen);
      // {pending, ext, vector}
      if (!ie)                return {2'b00, 16'h0000};
      if (hp  && !m[2])       return {2'b10, 16'h003C};
      if (mid && !m[1])       return {2'b10, 16'h0034};
      if (lo  && !m[0])       return {2'b10, 16'h002C};
      if (gen)                return {2'b11, 16'h0000};
      return {2'b00, 16'h0000};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [17:0] e;
      int lows;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc(); #1;
      // R1 reset state
      check("R1 stat", stat_out, 8'h07);
      check("R1 pending", irq_pending, 0);
      check("R1 ack_n", gen_ack_n, 1);

      // Sweep R4 R5 R6 R7 R11: mask x enable x hi latch x levels
      for (int m = 0; m < 8; m++) begin
         for (int ie = 0; ie < 2; ie++) begin
            for (int hp = 0; hp < 2; hp++) begin
               for (int lv = 0; lv < 8; lv++) begin
                  rst_mid_in = 0; rst_lo_in = 0; gen_req_in = 0;
                  write_mask(3'(m), 1'b1);
                  set_ie(1'(ie));
                  if (hp != 0) pulse_hi();
                  cyc();
                  rst_mid_in = lv[2]; rst_lo_in = lv[1]; gen_req_in = lv[0];
                  #1;
                  e = expect_sel(3'(m), 1'(ie), 1'(hp), lv[2], lv[1], lv[0]);
                  check("R4 R5 pending", irq_pending, e[17]);
                  check("R8 ext flag", irq_ext, e[16]);
                  check("R4 vector", irq_vector, e[15:0]);
                  check("R11 stat", stat_out,
                        {1'b0, 1'(hp), lv[2], lv[1], 1'(ie), 3'(m)});
               end
            end
         end
      end
      rst_mid_in = 0; rst_lo_in = 0; gen_req_in = 0;

      // R7 level drop withdraws in the same cycle
      write_mask(3'b000, 1'b1);
      set_ie(1);
      cyc(); rst_mid_in = 1; #1;
      check("R7 mid vector", irq_vector, 16'h0034);
      rst_mid_in = 0; #1;
      check("R7 mid withdrawn", irq_pending, 0);

      // R2 NMI ignores mask and enable
      write_mask(3'b111, 1'b1);
      set_ie(0);
      cyc(); nmi_in = 1;
      cyc(); #1;
      check("R2 nmi pending", irq_pending, 1);
      check("R2 nmi vector", irq_vector, 16'h0024);
      check("R2 nmi ext", irq_ext, 0);
      check("R11 nmi stat", stat_out[7], 1);
      // R3 dropping the line withdraws it
      nmi_in = 0; #1;
      check("R3 nmi drop", irq_pending, 0);
      cyc(); cyc(); #1;
      check("R3 nmi stays gone", irq_pending, 0);
      // R3 re-arm, take, no retrigger while held; R9 enable untouched by NMI take
      set_ie(1);
      cyc(); nmi_in = 1;
      cyc(); #1;
      check("R3 nmi re-arm", irq_vector, 16'h0024);
      irq_take = 1;
      cyc(); #1;
      check("R3 nmi no retrigger", irq_pending, 0);
      check("R9 nmi keeps ie", stat_out[3], 1);
      cyc(); #1;
      check("R3 nmi still quiet", irq_pending, 0);
      nmi_in = 0;

      // R10 R9 take of top restart
      write_mask(3'b000, 1'b1);
      set_ie(1);
      pulse_hi();
      cyc(); #1;
      check("R6 hi latched after drop", irq_vector, 16'h003C);
      irq_take = 1;
      cyc(); #1;
      check("R10 hi cleared by take", stat_out[6], 0);
      check("R9 ie cleared", stat_out[3], 0);
      check("R9 nothing pending", irq_pending, 0);

      // R6 latch while masked, then unmask; R10 clear by mask write
      write_mask(3'b100, 1'b1);
      set_ie(1);
      pulse_hi();
      cyc(); #1;
      check("R6 masked hi not presented", irq_pending, 0);
      check("R6 masked hi latched", stat_out[6], 1);
      write_mask(3'b000, 1'b0);
      cyc(); #1;
      check("R6 unmasked hi presented", irq_vector, 16'h003C);
      write_mask(3'b000, 1'b1);
      cyc(); #1;
      check("R10 mask-write clear", stat_out[6], 0);
      check("R10 nothing pending", irq_pending, 0);

      // R8 general request and acknowledge length
      write_mask(3'b111, 1'b1);
      set_ie(1);
      cyc(); gen_req_in = 1; #1;
      check("R8 ext presented", irq_ext, 1);
      check("R8 ext vector", irq_vector, 16'h0000);
      check("R8 ack idle", gen_ack_n, 1);
      irq_take = 1;
      lows = 0;
      for (int k = 0; k < ACK + 3; k++) begin
         cyc(); #1;
         if (gen_ack_n == 0) lows++;
         if (k == 0) begin
            check("R8 ack starts next cycle", gen_ack_n, 0);
            check("R9 ext take clears ie", irq_pending, 0);
         end
      end
      check("R8 ack length", lows, ACK);
      gen_req_in = 0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule